// File: doc/BRIEF.md
# Serial 1101 Pattern Detector (Mealy, Non-Overlapping)

The block watches a serial bit stream and takes one bit per clock whenever the qualifier `bit_valid` is high. It raises `hit` whenever the bits accepted so far end in the pattern 1101, oldest bit first. The output follows the Mealy form. `hit` is decoded from the stored progress through the pattern together with the bit now on `bit_in`. It therefore goes high during the same cycle that presents the closing 1, before the clock edge that accepts that bit.

Matches do not overlap. Once a match completes, the tracker goes back to its starting point, and the next match has to be built from four new bits. A synchronous reset clears the progress. While `bit_valid` is low, the tracker keeps its progress and `hit` stays low. The progress can be stored as a two-bit binary code or as four one-hot flops; a parameter selects which.

Top module: `seqdet_1101_mealy`

## Requirements
- R1: When `rst` is high at a rising edge, the tracker returns to the start with no pattern bits held. A 1 that arrived before the reset therefore cannot count toward a match.
- R2: `hit` is high in the cycle that presents a valid 1 when the three previously accepted bits, counted since the start or the last match, were 1, 1, 0. The output is combinational and needs no clock edge.
- R3: If a 0 arrives when 110 has been seen, `hit` stays low and the tracker restarts from the beginning.
- R4: Matches do not overlap. After a match, no accepted bit before it can contribute to the next match, so the stream 1101101 produces exactly one hit, on its fourth bit.
- R5: A run of three or more 1s keeps the last two 1s as a valid prefix, so the stream 11101 produces a hit on its fifth bit.
- R6: A cycle with `bit_valid` low leaves the progress unchanged and keeps `hit` low, whatever the value on `bit_in`.
- R7: A 0 that follows a lone 1 sends the tracker back to the start, so 101101 produces a single hit, on its sixth bit.
- R8: `hit` is never high in any cycle where the accepted bits do not complete a fresh 1101, as defined by R2 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | High when `bit_in` carries a bit to consume |
| hit | output | 1 | Combinational match flag for the current bit |

## Verification
The main function is run on every 10-bit stream. Each stream is fed once with no gaps and once with invalid cycles inserted whose `bit_in` carries the inverse of the next bit. The gap-free sweep covers every route through the tracker, including each place a match can overlap the one before it. The gapped sweep shows that a bit presented with `bit_valid` low neither moves the tracker nor raises `hit`. Short directed streams then pick out the cases a wrong restart would hide: 1101101, 11101, 101101, 1100 followed by 1101, and a reset in the middle of a pattern.

// File: rtl/sd_pkg.sv
package sd_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_11   = 2'd2,
      PH_110  = 2'd3
   } phase_t;
   localparam int NUM_PHASES = 4;
   localparam int PHASE_W    = $clog2(NUM_PHASES);
endpackage

// File: rtl/sd_step.sv
module sd_step
   import sd_pkg::*;
(
   input  phase_t cur,
   input  logic   bit_in,
   input  logic   bit_valid,
   output phase_t nxt,
   output logic   match
);
   always_comb begin
      nxt   = cur;
      match = 1'b0;
      if (bit_valid) begin
         unique case (cur)
            PH_IDLE: nxt = bit_in ? PH_ONE : PH_IDLE;
            PH_ONE:  nxt = bit_in ? PH_11  : PH_IDLE;
            PH_11:   nxt = bit_in ? PH_11  : PH_110;
            PH_110: begin
               nxt   = PH_IDLE;
               match = bit_in;
            end
            default: nxt = PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sd_phase_reg.sv
module sd_phase_reg
   import sd_pkg::*;
#(
   parameter int ONE_HOT = 0
) (
   input  logic   clk,
   input  logic   rst,
   input  phase_t nxt,
   output phase_t cur
);
   generate
      if (ONE_HOT != 0 && ONE_HOT != 1) begin : g_bad_cfg
         $error("sd_phase_reg: ONE_HOT must be 0 or 1");
      end

      if (ONE_HOT == 1) begin : g_onehot
         logic [NUM_PHASES-1:0] hot_q;
         always_ff @(posedge clk) begin
            if (rst) hot_q <= NUM_PHASES'(1);
            else     hot_q <= NUM_PHASES'(1) << nxt;
         end
         always_comb begin
            cur = PH_IDLE;
            for (int i = 0; i < NUM_PHASES; i++)
               if (hot_q[i]) cur = phase_t'(PHASE_W'(i));
         end
         a_r1_onehot_legal: assert property (@(posedge clk) disable iff (rst)
            $countones(hot_q) == 1);
      end else begin : g_binary
         phase_t code_q;
         always_ff @(posedge clk) begin
            if (rst) code_q <= PH_IDLE;
            else     code_q <= nxt;
         end
         assign cur = code_q;
      end
   endgenerate
endmodule

// File: rtl/seqdet_1101_mealy.sv
module seqdet_1101_mealy
   import sd_pkg::*;
#(
   parameter int ONE_HOT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   input  logic bit_valid,
   output logic hit
);
   phase_t cur;
   phase_t nxt;

   sd_step u_step (
      .cur       (cur),
      .bit_in    (bit_in),
      .bit_valid (bit_valid),
      .nxt       (nxt),
      .match     (hit)
   );

   sd_phase_reg #(.ONE_HOT(ONE_HOT)) u_reg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt),
      .cur (cur)
   );

   a_r1_reset_idle: assert property (@(posedge clk)
      rst |=> cur == PH_IDLE);
   a_r4_restart_after_hit: assert property (@(posedge clk) disable iff (rst)
      hit |=> cur == PH_IDLE);
   a_r2_hit_needs_one: assert property (@(posedge clk) disable iff (rst)
      hit |-> (bit_in && bit_valid && cur == PH_110));
   a_r5_ones_keep_prefix: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && bit_in && cur == PH_11) |=> cur == PH_11);
   a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !bit_valid |=> $stable(cur));
   a_r6_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
      !bit_valid |-> !hit);
   a_r3_zero_after_110: assert property (@(posedge clk) disable iff (rst)
      (bit_valid && !bit_in && cur == PH_110) |-> (!hit ##1 cur == PH_IDLE));
endmodule

// File: tb/sim_seqdet_1101_mealy.sv
module sim_seqdet_1101_mealy;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bit_in = 1'b0;
   logic bit_valid = 1'b0;
   logic hit;
   int checks = 0;
   int errors = 0;
   logic [3:0] hist;
   int since;

   always #5 clk = ~clk;

   seqdet_1101_mealy u0 (.clk(clk), .rst(rst), .bit_in(bit_in),
                         .bit_valid(bit_valid), .hit(hit));

   task automatic check(input logic exp, input string tag);
      checks++;
      if (hit !== exp) begin
         errors++;
         $display("FAIL %s: hit=%b expected=%b at %0t", tag, hit, exp, $time);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; bit_valid = 1'b0; bit_in = 1'b1;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
      hist = 4'b0; since = 0;
   endtask

   // drive at negedge, check before the next rising edge
   task automatic feed(input logic b, input string tag);
      logic e;
      @(negedge clk);
      bit_in = b; bit_valid = 1'b1;
      hist = {hist[2:0], b};
      since++;
      e = (since >= 4) && (hist == 4'b1101);
      if (e) since = 0;
      #1 check(e, tag);
   endtask

   task automatic gap(input logic b);
      @(negedge clk);
      bit_in = b; bit_valid = 1'b0;
      #1 check(1'b0, "R6");
   endtask

   task automatic feed_str(input logic [15:0] s, input int n, input string tag);
      for (int i = n - 1; i >= 0; i--) feed(s[i], tag);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      #1 check(1'b0, "R1");
      do_reset();
      // R4: overlapping second pattern must not fire
      feed_str(16'b1101101, 7, "R4");
      // R5: run of ones keeps prefix
      do_reset(); feed_str(16'b11101, 5, "R5");
      // R7: zero after a lone one restarts
      do_reset(); feed_str(16'b101101, 6, "R7");
      // R3: 1100 then a full pattern
      do_reset(); feed_str(16'b11001101, 8, "R3");
      // R1: reset mid-pattern discards the held 110
      do_reset(); feed_str(16'b110, 3, "R1");
      do_reset(); feed(1'b1, "R1"); feed(1'b1, "R1");
      // R6: gap inside a pattern, inverted bit offered
      do_reset(); feed(1'b1, "R6"); feed(1'b1, "R6"); gap(1'b1); feed(1'b0, "R6");
      gap(1'b0); gap(1'b1); feed(1'b1, "R6");
      // R2 / R8: exhaustive sweep, no gaps
      for (int s = 0; s < 1024; s++) begin
         do_reset();
         for (int i = 9; i >= 0; i--) feed(s[i], "R2/R8");
      end
      // R6 / R8: exhaustive sweep with gaps carrying the inverted next bit
      for (int s = 0; s < 1024; s++) begin
         do_reset();
         for (int i = 9; i >= 0; i--) begin
            if ((i + s) % 3 == 0) gap(~s[i]);
            feed(s[i], "R8");
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule